// File: doc/BRIEF.md
# Auto-Reload Down-Counting Interval Timer

This block is a 32-bit countdown timer with a small register interface. Software writes a start value into the load word. It then sets the run bit in the control word. From then on the counter steps down by one on every prescaled tick. When a tick brings the counter to zero, the block drives a single-cycle interrupt pulse. With auto-reload on, the next tick copies the load word back in and counting goes on, which gives a periodic event. With auto-reload off, the run bit clears itself and the count stays at zero, which gives a one-shot delay.

A clock-enable bit in the control word gates the prescaler and the counter, and it is separate from the run bit. The tick period is a power of two set by a three-bit prescale field. Auto-reload can be changed while the timer runs, so one unit covers both periodic and one-shot use. Loaded with all ones and set to auto-reload, the counter runs freely. Inverting what it reads then gives a rising time base.

Top module: `auto_reload_timer`

## Requirements
- R1: After reset the control word and the count read as zero and irq is low.
- R2: Byte offset 0x0 is the control word, readable and writable. Its bits are: bit 0 run, bit 1 auto-reload, bits 4:2 prescale, bit 5 clock enable. All other bits read zero. Offset 0x4 is the load word, which is write-only and reads zero. Offset 0x8 is the count, which is read-only. Any other offset reads zero. Read data appears in the cycle after the read strobe.
- R3: A write that takes the run bit from 0 to 1 copies the load word into the count and clears the prescaler. A load write on its own never changes the count.
- R4: With prescale value p, the count drops by one every 2^(p+1) clock cycles. The first step comes 2^(p+1) cycles after the start write.
- R5: irq is a one-cycle pulse, raised in the cycle after the tick that leaves the count at zero.
- R6: With auto-reload on, a tick taken at zero reloads the load word. A load value N therefore gives one interrupt every N+1 ticks, and a load of 0 gives one on every tick.
- R7: With auto-reload off, the tick that reaches zero also clears the run bit, and the count stays at zero.
- R8: Clearing the run bit halts counting and keeps the count unchanged.
- R9: While clock enable is 0, neither the prescaler nor the count advances, even with the run bit set. Register access still works.
- R10: Changing auto-reload while running leaves the count undisturbed. It only decides what happens at the next zero.
- R11: Loaded with all ones and with auto-reload on, the counter runs freely, and the bitwise inverse of its count rises over time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 4 | Byte address of the word |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after rd_en |
| irq | output | 1 | Single-cycle interrupt pulse |

## Verification
The counting path is driven with several patterns:
- A short one-shot, which separates run clearing from reloading.
- Periodic runs with a nonzero load and with a zero load, which show whether the period is N+1 ticks or N.
- A slow prescale setting, which exposes an off-by-one in the divider.
- A start with the clock gated, which shows whether enable is separate from run.
- A load write and an auto-reload change during a run, which separate "affects only the next zero" from "disturbs the current count".
- A free-running all-ones load, which checks exact count values far from zero.

// File: rtl/auto_reload_timer.sv
`timescale 1ns/1ps
module auto_reload_timer #(
  parameter int DW = 32,
  parameter int AW = 4,
  parameter int PW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq
);
  localparam int DIVW = 1 << PW;
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_LOAD = AW'(4);
  localparam logic [AW-1:0] A_CNT  = AW'(8);

  logic            st_q, ar_q, ce_q, irq_q;
  logic [PW-1:0]   pre_q;
  logic [DW-1:0]   load_q, cnt_q, rdata_q, rmux;
  logic [DIVW-1:0] div_q;

  wire wr_ctrl    = wr_en && addr == A_CTRL;
  wire wr_load    = wr_en && addr == A_LOAD;
  wire start_rise = wr_ctrl && wdata[0] && !st_q;
  wire run        = st_q && ce_q;

  wire [DIVW-1:0] div_lim = (DIVW'(1) << ({1'b0, pre_q} + 1'b1)) - DIVW'(1);
  wire            tick    = run && div_q >= div_lim;
  wire [DW-1:0]   cnt_nxt = (cnt_q == '0) ? load_q : cnt_q - DW'(1);
  wire            hit     = tick && cnt_nxt == '0;

  always_comb begin
    case (addr)
      A_CTRL:  rmux = DW'({ce_q, pre_q, ar_q, st_q});
      A_CNT:   rmux = cnt_q;
      default: rmux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= 1'b0;
      ar_q    <= 1'b0;
      ce_q    <= 1'b0;
      pre_q   <= '0;
      load_q  <= '0;
      cnt_q   <= '0;
      div_q   <= '0;
      irq_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      irq_q <= hit;
      if (rd_en) rdata_q <= rmux;
      if (wr_load) load_q <= wdata;
      if (wr_ctrl) begin
        st_q  <= wdata[0];
        ar_q  <= wdata[1];
        pre_q <= wdata[2 +: PW];
        ce_q  <= wdata[2 + PW];
      end else if (hit && !ar_q) begin
        st_q <= 1'b0;
      end
      if (start_rise) begin
        cnt_q <= load_q;
        div_q <= '0;
      end else if (tick) begin
        cnt_q <= cnt_nxt;
        div_q <= '0;
      end else if (run) begin
        div_q <= div_q + DIVW'(1);
      end
    end
  end

  assign rdata = rdata_q;
  assign irq   = irq_q;
endmodule

module auto_reload_timer_chk #(
  parameter int DW = 32,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          irq,
  input logic          st,
  input logic          ar,
  input logic          ce,
  input logic [DW-1:0] cnt,
  input logic          wr_en,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] wdata
);
  wire ctrl_wr = wr_en && addr == AW'(0);

  // R5
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) irq |=> !irq);
  // R5
  irq_zero_chk: assert property (@(posedge clk) disable iff (!rst_n) irq |-> cnt == '0);
  // R9
  gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce && !(ctrl_wr && wdata[0] && !st)) |=> $stable(cnt));
  // R8
  halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!st && !(ctrl_wr && wdata[0])) |=> $stable(cnt));
  // R4
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st && ce && cnt != '0) |=> (cnt == $past(cnt) || cnt == $past(cnt) - DW'(1)));
  // R7
  oneshot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !ar && !$past(ctrl_wr)) |-> !st);
endmodule

bind auto_reload_timer auto_reload_timer_chk #(.DW(DW), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .irq(irq_q), .st(st_q), .ar(ar_q), .ce(ce_q),
  .cnt(cnt_q), .wr_en(wr_en), .addr(addr), .wdata(wdata)
);

// File: tb/auto_reload_timer_test.sv
`timescale 1ns/1ps
module auto_reload_timer_test;
  logic        clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        irq;

  auto_reload_timer uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
                         .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  always #10 clk = ~clk;

  int cyc = 0, checks = 0, fails = 0, t_exp, s, w;
  int exp_q[$];
  string tag_q[$];
  string t_tag;
  logic [31:0] prev;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) if (rst_n) begin
    if (exp_q.size() > 0 && exp_q[0] < cyc) begin
      checks++; fails++;
      t_exp = exp_q.pop_front(); t_tag = tag_q.pop_front();
      $display("FAIL %s: irq missing, actual none, expected cycle %0d", t_tag, t_exp);
    end
    if (irq) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R5: irq at cycle %0d, expected none", cyc);
      end else begin
        t_exp = exp_q.pop_front(); t_tag = tag_q.pop_front();
        if (t_exp != cyc) begin
          fails++;
          $display("FAIL %s: irq at cycle %0d, expected %0d", t_tag, cyc, t_exp);
        end
      end
    end
  end

  function automatic logic [31:0] ctl(bit st, bit ar, logic [2:0] p, bit ce);
    return {26'b0, ce, p, ar, st};
  endfunction

  task automatic push(int t, string tag);
    exp_q.push_back(t); tag_q.push_back(tag);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, output int e);
    wr_en = 1; addr = a; wdata = d;
    @(posedge clk); #1 e = cyc;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0;
    cmp(tag, rdata, exp);
  endtask

  task automatic wait_until(int c);
    while (cyc < c) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks + 1, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    cmp("R1 irq", {31'b0, irq}, 32'h0);
    rd(4'h0, 32'h0, "R1 ctrl");
    rd(4'h8, 32'h0, "R1 count");

    wr(4'h0, 32'hFFFF_FFC0 | ctl(0, 1, 3'd5, 1), w);
    rd(4'h0, 32'h36, "R2 ctrl layout");
    wr(4'h4, 32'h1234, w);
    rd(4'h4, 32'h0, "R2 load reads zero");
    rd(4'hC, 32'h0, "R2 unmapped");
    rd(4'h8, 32'h0, "R3 load write leaves count");
    wr(4'h0, 32'h0, w);

    // one-shot, N=5, prescale 0
    wr(4'h4, 32'd5, w);
    wr(4'h0, ctl(1, 0, 0, 1), s);
    push(s + 10, "R7");
    rd(4'h8, 32'd5, "R3 start copies load");
    wait_until(s + 4);
    rd(4'h8, 32'd3, "R4 step every 2");
    wait_until(s + 14);
    rd(4'h0, 32'h20, "R7 run cleared");
    rd(4'h8, 32'h0, "R7 count at zero");

    // periodic, N=3
    wr(4'h4, 32'd3, w);
    wr(4'h0, ctl(1, 1, 0, 1), s);
    push(s + 6, "R6"); push(s + 14, "R6"); push(s + 22, "R6");
    wait_until(s + 26);
    wr(4'h0, ctl(0, 1, 0, 1), w);
    rd(4'h8, 32'd2, "R8 halted count");
    repeat (10) @(negedge clk);
    rd(4'h8, 32'd2, "R8 count kept");

    // periodic, N=0
    wr(4'h4, 32'd0, w);
    wr(4'h0, ctl(1, 1, 0, 1), s);
    push(s + 2, "R6"); push(s + 4, "R6"); push(s + 6, "R6");
    wait_until(s + 6);
    wr(4'h0, ctl(0, 1, 0, 1), w);
    repeat (6) @(negedge clk);

    // prescale 2 -> 8 clocks per tick
    wr(4'h4, 32'd2, w);
    wr(4'h0, ctl(1, 0, 3'd2, 1), s);
    push(s + 16, "R4");
    wait_until(s + 7);
    rd(4'h8, 32'd2, "R4 before first tick");
    rd(4'h8, 32'd1, "R4 after first tick");
    wait_until(s + 20);

    // clock enable off
    wr(4'h4, 32'd4, w);
    wr(4'h0, ctl(1, 0, 0, 0), s);
    repeat (20) @(negedge clk);
    rd(4'h8, 32'd4, "R9 frozen count");
    rd(4'h0, 32'h01, "R9 ctrl access");
    wr(4'h0, ctl(1, 0, 0, 1), w);
    push(w + 8, "R9");
    wait_until(w + 12);
    rd(4'h8, 32'd0, "R9 counted after enable");

    // load write while running
    wr(4'h4, 32'd6, w);
    wr(4'h0, ctl(1, 0, 0, 1), s);
    push(s + 12, "R3");
    wait_until(s + 3);
    wr(4'h4, 32'd50, w);
    wait_until(s + 16);

    // auto-reload cleared mid-run
    wr(4'h4, 32'd3, w);
    wr(4'h0, ctl(1, 1, 0, 1), s);
    push(s + 6, "R10");
    wait_until(s + 2);
    wr(4'h0, ctl(1, 0, 0, 1), w);
    rd(4'h8, 32'd2, "R10 count undisturbed");
    wait_until(s + 24);
    rd(4'h0, 32'h20, "R10 stopped at zero");

    // free running
    wr(4'h4, 32'hFFFF_FFFF, w);
    wr(4'h0, ctl(1, 1, 0, 1), s);
    wait_until(s + 10);
    rd(4'h8, 32'hFFFF_FFFA, "R11 free count");
    prev = ~rdata;
    wait_until(s + 100);
    rd(4'h8, 32'hFFFF_FFCD, "R11 free count later");
    cmp("R11 inverse rises", {31'b0, (~rdata > prev)}, 32'h1);
    wr(4'h0, ctl(0, 1, 0, 1), w);
    repeat (4) @(negedge clk);

    cmp("R5 all irqs seen", exp_q.size(), 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule